// File: doc/BRIEF.md
# Trapezoidal LED dimming sequencer

This block drives the brightness of one LED channel along a repeating trapezoid. It produces a 5-bit brightness code, and a separate PWM stage turns that code into a duty cycle. Once the waveform enable goes high, the block runs an optional start-up delay. It then loops through four phases: a ramp up, a plateau at the high level, a ramp down and a rest at the low level. During each ramp the code moves by one level at a time. Each intermediate level is held for a programmable number of time steps.

Every duration is counted in time steps. The length of a step is a power of two, 2^N, times a base step. The base step comes from one of two sources. The first is a fixed number of system clocks (BASE_DIV, nominally 50 µs). The second is 32 rising edges of an external sync input. The exact length of each phase follows off-by-one rules that depend on whether N is zero. A system with several channels places one instance per channel.

Top module: `trap_dim_seq`

## Requirements
- R1: After reset, and whenever `wave_en` is low, `code_out` is 0.
- R2: With `ext_sel`=0, a time step lasts BASE_DIV × 2^N clocks, where N is `step_exp` (0..7). The output changes only at step boundaries counted from the clock edge that samples `wave_en` high.
- R3: With `ext_sel`=1, a time step lasts 2^N × 32 rising edges of `sync_in`.
- R4: A delay count of 0 skips the delay phase. Otherwise the delay lasts `cnt_delay`+r steps when N=0, or (`cnt_delay`−1)+(r−1) steps when N≥1. The output holds `lvl_lo` during the delay. Here r is the effective rise count and f the effective fall count.
- R5: On the ramp up, the code passes through each level from `lvl_lo`+1 to `lvl_hi`−1 in turn, one level at a time. Each level is held r steps when N=0, or r−1 steps when N≥1. The ramp down passes through the levels from `lvl_hi`−1 to `lvl_lo`+1 the same way, using f. While enabled, with the levels held steady, the code stays between the two levels.
- R6: The plateau outputs `lvl_hi`. With N=0 it lasts `cnt_high`+f steps, or 1 step if `cnt_high`=0. With N≥1 it lasts (`cnt_high`−1)+(f−1) steps, or f−1 steps if `cnt_high` is 0 or 1.
- R7: The rest outputs `lvl_lo` and follows the R6 rules with `cnt_low` and r. After the rest, the sequence returns to the ramp up, not to the delay.
- R8: A rise or fall count of 0 or 1 is treated as 2. The effective count r (or f) is the programmed count, or 2 if that is smaller.
- R9: When `lvl_hi` ≤ `lvl_lo`+1, both ramps take zero steps. The output alternates directly between `lvl_hi` for the plateau and `lvl_lo` for the rest.
- R10: One clock after `wave_en` is sampled low, `code_out` is 0. The next rising enable restarts the sequence from the delay phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wave_en | input | 1 | Runs the waveform while high |
| ext_sel | input | 1 | 1 selects the sync input as the base time source |
| sync_in | input | 1 | External sync clock, sampled and edge-detected |
| step_exp | input | 3 | Time-step exponent N |
| lvl_lo | input | 5 | Low brightness level |
| lvl_hi | input | 5 | High brightness level |
| cnt_delay | input | 8 | Start-up delay count |
| cnt_rise | input | 8 | Steps per level on the ramp up |
| cnt_high | input | 8 | Plateau count |
| cnt_fall | input | 8 | Steps per level on the ramp down |
| cnt_low | input | 8 | Rest count |
| code_out | output | 5 | Registered brightness code |

## Verification
The code register loads its first value on the same edge that samples `wave_en` high. Each later change comes exactly a whole number of step periods after that edge. Disabling shows up as 0 one edge after `wave_en` is sampled low. The reference model advances on the same rising edges and counts step periods from the enabling edge. Outputs are compared on the falling edge, so every expected transition is checked in the cycle it is due. In external-sync mode the phase of the synchronised sync edge is not fixed relative to the enable, so the check there measures the clock distance between two successive ramp levels instead.

// File: rtl/tds_pkg.sv
package tds_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DELAY,
    PH_UP,
    PH_TOP,
    PH_DOWN,
    PH_REST
  } phase_e;
endpackage

// File: rtl/tds_tick_gen.sv
module tds_tick_gen #(
  parameter int BASE_DIV = 50,
  parameter int SYNC_DIV = 32,
  parameter int EXP_W    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             ext_sel,
  input  logic             sync_in,
  input  logic [EXP_W-1:0] step_exp,
  output logic             step_tick
);
  localparam int MAXDIV = (BASE_DIV > SYNC_DIV) ? BASE_DIV : SYNC_DIV;
  localparam int DIV_W  = $clog2(MAXDIV + 1);
  localparam int SCL_W  = (1 << EXP_W) - 1;

  logic [2:0]       sync_sh;
  logic             base_evt;
  logic             base_wrap;
  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] div_last;
  logic [SCL_W-1:0] scl_cnt;
  logic [SCL_W-1:0] scl_last;

  always_ff @(posedge clk) begin
    if (rst) sync_sh <= '0;
    else     sync_sh <= {sync_sh[1:0], sync_in};
  end

  always_comb begin
    base_evt  = ext_sel ? (sync_sh[1] & ~sync_sh[2]) : 1'b1;
    div_last  = ext_sel ? DIV_W'(SYNC_DIV - 1) : DIV_W'(BASE_DIV - 1);
    scl_last  = SCL_W'((32'd1 << step_exp) - 32'd1);
    base_wrap = base_evt && (div_cnt == div_last);
    step_tick = run && base_wrap && (scl_cnt == scl_last);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      div_cnt <= '0;
      scl_cnt <= '0;
    end else if (base_evt) begin
      if (base_wrap) begin
        div_cnt <= '0;
        scl_cnt <= (scl_cnt == scl_last) ? '0 : scl_cnt + SCL_W'(1);
      end else begin
        div_cnt <= div_cnt + DIV_W'(1);
      end
    end
  end

  generate
    if (BASE_DIV > 1) begin : g_gap_chk
      // R2: with the internal base, two steps never fall on adjacent clocks
      p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
        (step_tick && !ext_sel) |=> (ext_sel || !step_tick));
    end
  endgenerate
endmodule

// File: rtl/tds_phase_seq.sv
module tds_phase_seq
  import tds_pkg::*;
#(
  parameter int CODE_W = 5,
  parameter int CNT_W  = 8,
  parameter int EXP_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              step_tick,
  input  logic [EXP_W-1:0]  step_exp,
  input  logic [CODE_W-1:0] lvl_lo,
  input  logic [CODE_W-1:0] lvl_hi,
  input  logic [CNT_W-1:0]  n_delay,
  input  logic [CNT_W-1:0]  n_rise,
  input  logic [CNT_W-1:0]  n_high,
  input  logic [CNT_W-1:0]  n_fall,
  input  logic [CNT_W-1:0]  n_low,
  output logic              running,
  output logic [CODE_W-1:0] code
);
  localparam int LEN_W = CNT_W + 1;

  phase_e            phase_q;
  logic [CODE_W-1:0] code_q;
  logic [LEN_W-1:0]  left_q;

  logic [LEN_W-1:0]  r_eff, f_eff, hold_r, hold_f;
  logic [LEN_W-1:0]  dly_len, top_len, rest_len;
  logic              exp_zero, ramp_ok;
  phase_e            up_ph, dn_ph;
  logic [CODE_W-1:0] up_code, dn_code;
  logic [LEN_W-1:0]  up_len, dn_len;

  always_comb begin
    r_eff    = (n_rise < CNT_W'(2)) ? LEN_W'(2) : LEN_W'(n_rise);
    f_eff    = (n_fall < CNT_W'(2)) ? LEN_W'(2) : LEN_W'(n_fall);
    exp_zero = (step_exp == '0);
    hold_r   = exp_zero ? r_eff : r_eff - LEN_W'(1);
    hold_f   = exp_zero ? f_eff : f_eff - LEN_W'(1);

    if (n_delay == '0)  dly_len = '0;
    else if (exp_zero)  dly_len = LEN_W'(n_delay) + r_eff;
    else                dly_len = LEN_W'(n_delay) + r_eff - LEN_W'(2);

    if (exp_zero) top_len = (n_high == '0) ? LEN_W'(1) : LEN_W'(n_high) + f_eff;
    else          top_len = (n_high <= CNT_W'(1)) ? f_eff - LEN_W'(1)
                                                  : LEN_W'(n_high) + f_eff - LEN_W'(2);
    if (exp_zero) rest_len = (n_low == '0) ? LEN_W'(1) : LEN_W'(n_low) + r_eff;
    else          rest_len = (n_low <= CNT_W'(1)) ? r_eff - LEN_W'(1)
                                                  : LEN_W'(n_low) + r_eff - LEN_W'(2);

    ramp_ok = {1'b0, lvl_hi} > ({1'b0, lvl_lo} + (CODE_W+1)'(1));

    // entry into the ramp up, or straight to the plateau when there is no ramp
    up_ph   = ramp_ok ? PH_UP : PH_TOP;
    up_code = ramp_ok ? lvl_lo + CODE_W'(1) : lvl_hi;
    up_len  = ramp_ok ? hold_r : top_len;
    // entry into the ramp down, or straight to the rest
    dn_ph   = ramp_ok ? PH_DOWN : PH_REST;
    dn_code = ramp_ok ? lvl_hi - CODE_W'(1) : lvl_lo;
    dn_len  = ramp_ok ? hold_f : rest_len;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      phase_q <= PH_IDLE;
      code_q  <= '0;
      left_q  <= '0;
    end else if (phase_q == PH_IDLE) begin
      if (dly_len != '0) begin
        phase_q <= PH_DELAY;
        code_q  <= lvl_lo;
        left_q  <= dly_len;
      end else begin
        phase_q <= up_ph;
        code_q  <= up_code;
        left_q  <= up_len;
      end
    end else if (step_tick) begin
      if (left_q > LEN_W'(1)) begin
        left_q <= left_q - LEN_W'(1);
      end else begin
        unique case (phase_q)
          PH_DELAY, PH_REST: begin
            phase_q <= up_ph;
            code_q  <= up_code;
            left_q  <= up_len;
          end
          PH_UP: begin
            if (code_q + CODE_W'(1) == lvl_hi) begin
              phase_q <= PH_TOP;
              code_q  <= lvl_hi;
              left_q  <= top_len;
            end else begin
              code_q  <= code_q + CODE_W'(1);
              left_q  <= hold_r;
            end
          end
          PH_TOP: begin
            phase_q <= dn_ph;
            code_q  <= dn_code;
            left_q  <= dn_len;
          end
          PH_DOWN: begin
            if (code_q - CODE_W'(1) == lvl_lo) begin
              phase_q <= PH_REST;
              code_q  <= lvl_lo;
              left_q  <= rest_len;
            end else begin
              code_q  <= code_q - CODE_W'(1);
              left_q  <= hold_f;
            end
          end
          default: phase_q <= PH_IDLE;
        endcase
      end
    end
  end

  assign running = (phase_q != PH_IDLE);
  assign code    = code_q;

  // R5: on the ramp up the code never moves by more than one level per update
  p_ramp_unit_r5: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_UP) |=> (phase_q != PH_UP || code_q == $past(code_q) ||
                            code_q == $past(code_q) + CODE_W'(1)));

  // R2: while running, the code only moves on a time-step boundary
  p_step_only_r2: assert property (@(posedge clk) disable iff (rst)
    (en && phase_q != PH_IDLE && !step_tick) |=> $stable(code_q));
endmodule

// File: rtl/trap_dim_seq.sv
module trap_dim_seq #(
  parameter int CODE_W   = 5,
  parameter int CNT_W    = 8,
  parameter int EXP_W    = 3,
  parameter int BASE_DIV = 50,
  parameter int SYNC_DIV = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wave_en,
  input  logic              ext_sel,
  input  logic              sync_in,
  input  logic [EXP_W-1:0]  step_exp,
  input  logic [CODE_W-1:0] lvl_lo,
  input  logic [CODE_W-1:0] lvl_hi,
  input  logic [CNT_W-1:0]  cnt_delay,
  input  logic [CNT_W-1:0]  cnt_rise,
  input  logic [CNT_W-1:0]  cnt_high,
  input  logic [CNT_W-1:0]  cnt_fall,
  input  logic [CNT_W-1:0]  cnt_low,
  output logic [CODE_W-1:0] code_out
);
  logic running;
  logic step_tick;
  logic [CODE_W-1:0] lo_b, hi_b;

  tds_tick_gen #(
    .BASE_DIV (BASE_DIV),
    .SYNC_DIV (SYNC_DIV),
    .EXP_W    (EXP_W)
  ) u_tick (
    .clk       (clk),
    .rst       (rst),
    .run       (running),
    .ext_sel   (ext_sel),
    .sync_in   (sync_in),
    .step_exp  (step_exp),
    .step_tick (step_tick)
  );

  tds_phase_seq #(
    .CODE_W (CODE_W),
    .CNT_W  (CNT_W),
    .EXP_W  (EXP_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .en        (wave_en),
    .step_tick (step_tick),
    .step_exp  (step_exp),
    .lvl_lo    (lvl_lo),
    .lvl_hi    (lvl_hi),
    .n_delay   (cnt_delay),
    .n_rise    (cnt_rise),
    .n_high    (cnt_high),
    .n_fall    (cnt_fall),
    .n_low     (cnt_low),
    .running   (running),
    .code      (code_out)
  );

  assign lo_b = (lvl_lo < lvl_hi) ? lvl_lo : lvl_hi;
  assign hi_b = (lvl_lo < lvl_hi) ? lvl_hi : lvl_lo;

  // R10: a low enable clears the code on the next edge
  p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !wave_en |=> (code_out == '0));

  // R5 / R9: while enabled, the code stays inside the programmed band
  p_in_band_r5: assert property (@(posedge clk) disable iff (rst)
    (wave_en && $stable(lvl_lo) && $stable(lvl_hi)) |=>
      (!wave_en || (code_out >= lo_b && code_out <= hi_b)));
endmodule

// File: tb/trap_dim_seq_tb.sv
module trap_dim_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BD = 3;
  localparam int SD = 32;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wave_en = 1'b0;
  logic       ext_sel = 1'b0;
  logic       sync_in = 1'b0;
  logic [2:0] step_exp = '0;
  logic [4:0] lvl_lo = '0, lvl_hi = '0;
  logic [7:0] cnt_delay = '0, cnt_rise = 8'd2, cnt_high = '0, cnt_fall = 8'd2, cnt_low = '0;
  logic [4:0] code_out;

  int    n_checks = 0;
  int    n_fail = 0;
  string req_tag = "R1";
  bit    model_on = 1'b1;
  bit    finished = 1'b0;
  int    sdiv = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_dim_seq #(.BASE_DIV(BD), .SYNC_DIV(SD)) u_dut (
    .clk(clk), .rst(rst), .wave_en(wave_en), .ext_sel(ext_sel), .sync_in(sync_in),
    .step_exp(step_exp), .lvl_lo(lvl_lo), .lvl_hi(lvl_hi), .cnt_delay(cnt_delay),
    .cnt_rise(cnt_rise), .cnt_high(cnt_high), .cnt_fall(cnt_fall), .cnt_low(cnt_low),
    .code_out(code_out)
  );

  // sync clock: one period every four system clocks
  always @(negedge clk) begin
    sdiv <= sdiv + 1;
    if (sdiv % 2 == 1) sync_in <= ~sync_in;
  end

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int q_code[$];
  int q_len[$];
  int loop_ix, seg, left, step_clks, exp_code;
  bit act;

  function automatic int eff(int v);
    return (v < 2) ? 2 : v;
  endfunction

  task automatic build_profile();
    int r, f, n, d, hl, ll;
    r = eff(cnt_rise); f = eff(cnt_fall); n = step_exp;
    q_code.delete(); q_len.delete();
    if (cnt_delay == 0) d = 0;
    else if (n == 0) d = cnt_delay + r;
    else d = (cnt_delay - 1) + (r - 1);
    if (n == 0) hl = (cnt_high == 0) ? 1 : cnt_high + f;
    else hl = (cnt_high <= 1) ? f - 1 : (cnt_high - 1) + (f - 1);
    if (n == 0) ll = (cnt_low == 0) ? 1 : cnt_low + r;
    else ll = (cnt_low <= 1) ? r - 1 : (cnt_low - 1) + (r - 1);
    if (d > 0) begin q_code.push_back(lvl_lo); q_len.push_back(d); end
    loop_ix = q_code.size();
    for (int lv = lvl_lo + 1; lv < lvl_hi; lv++) begin
      q_code.push_back(lv); q_len.push_back(n == 0 ? r : r - 1);
    end
    q_code.push_back(lvl_hi); q_len.push_back(hl);
    for (int lv = lvl_hi - 1; lv > lvl_lo; lv--) begin
      q_code.push_back(lv); q_len.push_back(n == 0 ? f : f - 1);
    end
    q_code.push_back(lvl_lo); q_len.push_back(ll);
    step_clks = BD * (1 << n);
  endtask

  always @(posedge clk) begin
    if (rst || !wave_en) begin
      act = 1'b0;
      exp_code = 0;
    end else if (!act) begin
      build_profile();
      act = 1'b1;
      seg = 0;
      exp_code = q_code[0];
      left = q_len[0] * step_clks;
    end else begin
      left = left - 1;
      if (left == 0) begin
        seg = seg + 1;
        if (seg == q_code.size()) seg = loop_ix;
        exp_code = q_code[seg];
        left = q_len[seg] * step_clks;
      end
    end
  end

  always @(negedge clk) begin
    if (model_on && !rst) check(req_tag, code_out, exp_code);
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(int lo, int hi, int ex, int dl, int ri, int hg, int fa, int lw);
    lvl_lo = 5'(lo); lvl_hi = 5'(hi); step_exp = 3'(ex);
    cnt_delay = 8'(dl); cnt_rise = 8'(ri); cnt_high = 8'(hg);
    cnt_fall = 8'(fa); cnt_low = 8'(lw);
  endtask

  int t_a, t_b, guard;

  initial begin
    cycles(4);
    rst = 1'b0;
    // R1: reset state and disabled output
    req_tag = "R1";
    cycles(5);
    check("R1", code_out, 0);

    // R5 R6 R7: N=0 ramps with several levels, no delay
    req_tag = "R5";
    setup(3, 7, 0, 0, 2, 2, 3, 0);
    wave_en = 1'b1;
    cycles(150);
    wave_en = 1'b0;
    cycles(2);

    // R4: delay with N=1, then R10 abort and restart
    req_tag = "R4";
    setup(0, 4, 1, 4, 3, 1, 2, 5);
    wave_en = 1'b1;
    cycles(3);
    check("R4", code_out, 0);   // delay holds the low level
    cycles(120);
    req_tag = "R10";
    wave_en = 1'b0;
    cycles(1);
    check("R10", code_out, 0);
    wave_en = 1'b1;
    cycles(200);
    wave_en = 1'b0;
    cycles(2);

    // R8: illegal rise/fall counts treated as 2, N=2
    req_tag = "R8";
    setup(10, 13, 2, 1, 0, 3, 1, 0);
    wave_en = 1'b1;
    cycles(200);
    wave_en = 1'b0;
    cycles(2);

    // R9: high not above low, direct toggling
    req_tag = "R9";
    setup(9, 5, 0, 0, 2, 1, 2, 2);
    wave_en = 1'b1;
    cycles(100);
    wave_en = 1'b0;
    cycles(2);
    req_tag = "R9";
    setup(6, 7, 0, 2, 2, 0, 2, 1);
    wave_en = 1'b1;
    cycles(80);
    wave_en = 1'b0;
    cycles(2);

    // R2: longest exponent
    req_tag = "R2";
    setup(0, 2, 7, 0, 2, 0, 2, 0);
    wave_en = 1'b1;
    cycles(1700);
    wave_en = 1'b0;
    cycles(2);

    // R3: external sync base, measured level-to-level spacing
    model_on = 1'b0;
    ext_sel = 1'b1;
    setup(0, 3, 1, 0, 3, 0, 2, 0);
    wave_en = 1'b1;
    cycles(1);
    check("R3", code_out, 1);
    guard = 0;
    while (code_out != 2 && guard < 5000) begin cycles(1); guard++; end
    t_a = guard;
    while (code_out != 3 && guard < 5000) begin cycles(1); guard++; end
    t_b = guard;
    check("R3", t_b - t_a, 2 * SD * 4 * 2);
    wave_en = 1'b0;
    cycles(2);
    check("R10", code_out, 0);
    ext_sel = 1'b0;
    model_on = 1'b1;
    cycles(3);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule